// File: doc/BRIEF.md
# Correlating Global-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken. It keeps a table of 2-bit saturating counters and a short shift register of the most recent resolved branch outcomes. The counter that predicts a branch is chosen by mixing low-order bits of the branch address with that outcome history. The same branch address can therefore use a different counter for each recent outcome pattern, which lets the block learn branches whose direction depends on the branches before them.

A fetch stage presents a PC on the prediction port and gets a taken / not-taken answer in the same cycle, with no register on the way. When a branch resolves, the pipeline presents its PC and real outcome on the update port. The counter chosen by the current history and that PC moves one step toward the outcome, and the outcome is then shifted into the history. A parameter picks how address and history are combined: placed side by side (select mode) or XORed (share mode). With zero history bits the block becomes a plain address-indexed counter table.

Each counter is a four-state machine: STRONG_NT (00), WEAK_NT (01), WEAK_T (10) and STRONG_T (11). A taken outcome steps STRONG_NT to WEAK_NT, WEAK_NT to WEAK_T and WEAK_T to STRONG_T, and leaves STRONG_T where it is. A not-taken outcome steps STRONG_T to WEAK_T, WEAK_T to WEAK_NT and WEAK_NT to STRONG_NT, and leaves STRONG_NT where it is. WEAK_T and STRONG_T predict taken.

Top module: `cbp_predictor`

## Requirements
- R1: After reset every counter is WEAK_NT (01) and the history is all zeros, so every PC is predicted not taken.
- R2: `pred_taken` is bit 1 of the counter selected by `pred_pc` and the current history (10 and 11 give 1, 00 and 01 give 0), valid in the same cycle as `pred_pc`.
- R3: On a valid update the selected counter moves one step up for taken and one step down for not taken, holding at 11 and at 00, so a strong state needs two opposite outcomes to flip the prediction.
- R4: An update changes only the one counter selected by the current history and `upd_pc`; counters of the same address under other history patterns keep their values.
- R5: On a valid update the history shifts left by one and the outcome (1 = taken) enters bit 0.
- R6: With SHARE = 0 the index is {history, pc[ADDR_W+1:2]}, history in the upper bits.
- R7: With SHARE = 1 the index is pc[ADDR_W+1:2] XOR the history, both zero-extended to the larger of the two widths.
- R8: With HIST_W = 0 the index is pc[ADDR_W+1:2] alone and the history plays no part.
- R9: No tag is kept: PC bits [1:0] and bits above ADDR_W+1 do not affect the index, so PCs equal in bits [ADDR_W+1:2] share counters.
- R10: When the prediction and an update select the same counter in one cycle, `pred_taken` reflects the value before the update.
- R11: While `upd_valid` is 0 neither the counters nor the history change, whatever `upd_pc` and `upd_taken` hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| pred_pc | input | PC_W | Fetch PC to predict |
| pred_taken | output | 1 | Predicted direction, 1 = taken |
| upd_valid | input | 1 | A resolved branch is presented this cycle |
| upd_pc | input | PC_W | PC of the resolved branch |
| upd_taken | input | 1 | Real outcome, 1 = taken |

## Verification
`pred_taken` is due in the same cycle as `pred_pc`, while an update's effect on the counters and the history is due from the first rising edge after `upd_valid` is seen. The bench drives inputs at the falling edge and samples `pred_taken` one time unit later, so a prediction made in the cycle of an update shows the old counter and any effect of that update is read only from the next falling edge on. History effects are checked indirectly, by steering later updates and predictions to counters whose values depend on which history pattern was in force.

// File: rtl/cbp_pkg.sv
package cbp_pkg;

    typedef enum logic [1:0] {
        CTR_SNT = 2'b00,
        CTR_WNT = 2'b01,
        CTR_WT  = 2'b10,
        CTR_ST  = 2'b11
    } ctr_e;

    function automatic ctr_e ctr_step(input ctr_e cur, input logic taken);
        ctr_e nxt;
        unique case (cur)
            CTR_SNT: nxt = taken ? CTR_WNT : CTR_SNT;
            CTR_WNT: nxt = taken ? CTR_WT  : CTR_SNT;
            CTR_WT:  nxt = taken ? CTR_ST  : CTR_WNT;
            CTR_ST:  nxt = taken ? CTR_ST  : CTR_WT;
            default: nxt = cur;
        endcase
        return nxt;
    endfunction

endpackage

// File: rtl/cbp_hist.sv
module cbp_hist #(
    parameter int HIST_W = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              upd,
    input  logic              taken,
    output logic [HIST_W-1:0] hist
);
    logic [HIST_W-1:0] hist_q;
    logic [HIST_W-1:0] hist_d;

    always_comb begin
        hist_d = (hist_q << 1) | HIST_W'(taken);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hist_q <= '0;
        end else if (upd) begin
            hist_q <= hist_d;
        end
    end

    assign hist = hist_q;

    p_newest_bit0_r5: assert property (@(posedge clk) disable iff (!rst_n)
        upd |=> hist_q[0] == $past(taken));

    p_hist_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !upd |=> $stable(hist_q));

    generate
        if (HIST_W > 1) begin : g_shift_chk
            p_older_shift_r5: assert property (@(posedge clk) disable iff (!rst_n)
                upd |=> hist_q[HIST_W-1:1] == $past(hist_q[HIST_W-2:0]));
        end
    endgenerate

endmodule

// File: rtl/cbp_index.sv
module cbp_index #(
    parameter int PC_W   = 32,
    parameter int ADDR_W = 10,
    parameter int HIST_W = 2,
    parameter int HW1    = 2,
    parameter int IDX_W  = 12,
    parameter bit SHARE  = 1'b0
) (
    input  logic [PC_W-1:0]  pc,
    input  logic [HW1-1:0]   hist,
    output logic [IDX_W-1:0] idx
);
    logic [ADDR_W-1:0] addr;
    logic              unused_pc;

    assign addr      = pc[ADDR_W+1:2];
    assign unused_pc = ^{pc[PC_W-1:ADDR_W+2], pc[1:0]};

    generate
        if (HIST_W == 0) begin : g_flat
            logic unused_hist;
            assign unused_hist = ^hist;
            assign idx = addr;
        end else if (!SHARE) begin : g_select
            assign idx = {hist, addr};
        end else begin : g_share
            logic [IDX_W-1:0] a_ext;
            logic [IDX_W-1:0] h_ext;
            assign a_ext = IDX_W'(addr);
            assign h_ext = IDX_W'(hist);
            assign idx   = a_ext ^ h_ext;
        end
    endgenerate

endmodule

// File: rtl/cbp_ctr_table.sv
module cbp_ctr_table
    import cbp_pkg::*;
#(
    parameter int IDX_W = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic             rd_taken,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic             wr_taken
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DEPTH-1:0][1:0] tbl_q;
    ctr_e                  cur_w;
    ctr_e                  nxt_w;

    // next state of the counter being trained
    always_comb begin
        cur_w = ctr_e'(tbl_q[wr_idx]);
        nxt_w = ctr_step(cur_w, wr_taken);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tbl_q <= {DEPTH{CTR_WNT}};
        end else if (wr_en) begin
            tbl_q[wr_idx] <= nxt_w;
        end
    end

    // output: read of the registered state, so a same-cycle write is not seen
    always_comb begin
        rd_taken = tbl_q[rd_idx][1];
    end

    p_taken_up_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && wr_taken |=>
            (tbl_q[$past(wr_idx)] == 2'b11) ||
            (tbl_q[$past(wr_idx)] == $past(tbl_q[wr_idx]) + 2'd1));

    p_ntaken_down_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && !wr_taken |=>
            (tbl_q[$past(wr_idx)] == 2'b00) ||
            (tbl_q[$past(wr_idx)] == $past(tbl_q[wr_idx]) - 2'd1));

    p_other_kept_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en && (rd_idx != wr_idx) |=>
            tbl_q[$past(rd_idx)] == $past(tbl_q[rd_idx]));

    p_table_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(tbl_q));

endmodule

// File: rtl/cbp_predictor.sv
module cbp_predictor #(
    parameter int PC_W   = 32,
    parameter int ADDR_W = 10,
    parameter int HIST_W = 2,
    parameter bit SHARE  = 1'b0
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic [PC_W-1:0] pred_pc,
    output logic            pred_taken,
    input  logic            upd_valid,
    input  logic [PC_W-1:0] upd_pc,
    input  logic            upd_taken
);
    localparam int HW1   = (HIST_W > 0) ? HIST_W : 1;
    localparam int WMAX  = (ADDR_W > HIST_W) ? ADDR_W : HIST_W;
    localparam int IDX_W = (HIST_W == 0) ? ADDR_W :
                           (SHARE ? WMAX : ADDR_W + HIST_W);

    logic [HW1-1:0]   hist;
    logic [IDX_W-1:0] rd_idx;
    logic [IDX_W-1:0] wr_idx;

    generate
        if (HIST_W > 0) begin : g_hist
            cbp_hist #(.HIST_W(HIST_W)) u_hist (
                .clk   (clk),
                .rst_n (rst_n),
                .upd   (upd_valid),
                .taken (upd_taken),
                .hist  (hist)
            );
        end else begin : g_no_hist
            assign hist = '0;
        end
    endgenerate

    cbp_index #(
        .PC_W(PC_W), .ADDR_W(ADDR_W), .HIST_W(HIST_W),
        .HW1(HW1), .IDX_W(IDX_W), .SHARE(SHARE)
    ) u_rd_index (
        .pc   (pred_pc),
        .hist (hist),
        .idx  (rd_idx)
    );

    cbp_index #(
        .PC_W(PC_W), .ADDR_W(ADDR_W), .HIST_W(HIST_W),
        .HW1(HW1), .IDX_W(IDX_W), .SHARE(SHARE)
    ) u_wr_index (
        .pc   (upd_pc),
        .hist (hist),
        .idx  (wr_idx)
    );

    cbp_ctr_table #(.IDX_W(IDX_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .rd_idx   (rd_idx),
        .rd_taken (pred_taken),
        .wr_en    (upd_valid),
        .wr_idx   (wr_idx),
        .wr_taken (upd_taken)
    );

    p_same_pc_same_idx_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (pred_pc[ADDR_W+1:2] == upd_pc[ADDR_W+1:2]) |-> (rd_idx == wr_idx));

endmodule

// File: tb/cbp_predictor_bench.sv
module cbp_predictor_bench;
    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 12;

    // {pc, outcome, expected prediction before the update}
    localparam logic [33:0] VECS [NVEC] = '{
        {32'h0000_0100, 1'b1, 1'b0},
        {32'h0000_0100, 1'b1, 1'b0},
        {32'h0000_0100, 1'b1, 1'b0},
        {32'h0000_0100, 1'b1, 1'b1},
        {32'h0000_0100, 1'b0, 1'b1},
        {32'h0000_0100, 1'b0, 1'b0},
        {32'h0000_0100, 1'b0, 1'b1},
        {32'h0000_0100, 1'b1, 1'b0},
        {32'h0000_0100, 1'b1, 1'b1},
        {32'h0000_0100, 1'b0, 1'b1},
        {32'h0000_0100, 1'b1, 1'b0},
        {32'h0000_0100, 1'b1, 1'b1}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] pred_pc = '0;
    logic        upd_valid = 1'b0;
    logic [31:0] upd_pc = '0;
    logic        upd_taken = 1'b0;
    logic        pt_sel, pt_xor, pt_flat;
    int          checks = 0;
    int          errors = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cbp_predictor u_cbp_predictor (
        .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pt_sel),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken));

    cbp_predictor #(.SHARE(1'b1)) u_cbp_predictor_xor (
        .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pt_xor),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken));

    cbp_predictor #(.HIST_W(0)) u_cbp_predictor_flat (
        .clk(clk), .rst_n(rst_n), .pred_pc(pred_pc), .pred_taken(pt_flat),
        .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_taken(upd_taken));

    task automatic check(input logic got, input logic exp, input string what);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s: got %0b expected %0b", what, got, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n     = 1'b0;
        upd_valid = 1'b0;
        @(negedge clk);
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    // one valid update, committed at the rising edge inside the task
    task automatic upd(input logic [31:0] pc, input logic t);
        @(negedge clk);
        upd_valid = 1'b1;
        upd_pc    = pc;
        upd_taken = t;
        @(negedge clk);
        upd_valid = 1'b0;
    endtask

    task automatic look(input logic [31:0] pc);
        pred_pc = pc;
        #1;
    endtask

    initial begin
        do_reset();

        // R1: reset state
        look(32'h0000_0100); check(pt_sel,  1'b0, "R1 select reset");
        look(32'h0000_0ABC); check(pt_xor,  1'b0, "R1 share reset");
        look(32'h0000_0ABC); check(pt_flat, 1'b0, "R1 flat reset");

        // R2 R4 R6 R10: vector walk, same PC predicted and updated each cycle
        for (int i = 0; i < NVEC; i++) begin
            @(negedge clk);
            pred_pc   = VECS[i][33:2];
            upd_pc    = VECS[i][33:2];
            upd_taken = VECS[i][1];
            upd_valid = 1'b1;
            #1;
            check(pt_sel, VECS[i][0], $sformatf("R2/R4/R10 vector %0d", i));
        end
        @(negedge clk);
        upd_valid = 1'b0;

        // R11 R5: ignored updates leave counters and history alone
        do_reset();
        @(negedge clk);
        upd_pc = 32'h0000_0100; upd_taken = 1'b1; upd_valid = 1'b0;
        repeat (3) @(negedge clk);
        look(32'h0000_0100); check(pt_flat, 1'b0, "R11 counter untouched");
        upd(32'h0000_0100, 1'b1);          // {00,A} -> 10, hist 01
        upd(32'h0000_0200, 1'b0);          // hist 10
        upd(32'h0000_0200, 1'b0);          // hist 00
        look(32'h0000_0100); check(pt_sel, 1'b1, "R5/R11 history shifted only on valid");

        // R3: low saturation then one taken is not enough
        do_reset();
        upd(32'h0000_0200, 1'b0);
        upd(32'h0000_0200, 1'b0);
        upd(32'h0000_0200, 1'b1);          // {00,B} 00 -> 01, hist 01
        upd(32'h0000_0300, 1'b0);
        upd(32'h0000_0300, 1'b0);          // hist 00
        look(32'h0000_0200); check(pt_sel, 1'b0, "R3 hold at 00");

        // R3 R8: high saturation and two mispredictions to flip (flat table)
        do_reset();
        repeat (4) upd(32'h0000_0100, 1'b1);
        look(32'h0000_0100); check(pt_flat, 1'b1, "R3 saturate at 11");
        upd(32'h0000_0100, 1'b0);
        look(32'h0000_0100); check(pt_flat, 1'b1, "R3 one miss keeps taken");
        upd(32'h0000_0100, 1'b0);
        look(32'h0000_0100); check(pt_flat, 1'b0, "R3 second miss flips");

        // R6 R7 R8: index forms compared on the same stimulus
        do_reset();
        upd(32'h0000_0004, 1'b1);          // addr 1 trained, hist 01
        look(32'h0000_0000);
        check(pt_sel,  1'b0, "R6 select addr0 hist01");
        check(pt_xor,  1'b1, "R7 share addr0^01 hits trained entry");
        check(pt_flat, 1'b0, "R8 flat addr0");
        look(32'h0000_0004);
        check(pt_sel,  1'b0, "R6 select addr1 hist01 untrained");
        check(pt_xor,  1'b0, "R7 share addr1^01 untrained");
        check(pt_flat, 1'b1, "R8 flat addr1 ignores history");

        // R9: alias by upper and low PC bits
        do_reset();
        upd(32'h0000_0100, 1'b1);          // hist 01
        upd(32'h0000_0300, 1'b0);
        upd(32'h0000_0300, 1'b0);          // hist 00
        look(32'h0000_1103);
        check(pt_sel,  1'b1, "R9 select alias");
        check(pt_flat, 1'b1, "R9 flat alias");

        // R10: same-cycle read returns the old counter
        do_reset();
        @(negedge clk);
        pred_pc = 32'h0000_0100; upd_pc = 32'h0000_0100;
        upd_taken = 1'b1; upd_valid = 1'b1;
        #1;
        check(pt_flat, 1'b0, "R10 pre-update value");
        @(negedge clk);
        upd_valid = 1'b0;
        #1;
        check(pt_flat, 1'b1, "R10 post-update value");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule